// File: doc/BRIEF.md
# Stereo I2S Serial Audio Transmitter

This block carries stereo samples from a core clock domain to a serial audio link. Each stereo pair has a left and a right sample. On every core clock cycle where a valid strobe is high, the pair is formatted into two signed 16-bit words and written into a small asynchronous FIFO.

The audio side runs from its own reference clock. From that clock it builds a bit clock at 64 times the sample rate and a word-select that marks the left and right slots. It also shifts the sample words out MSB first on a single data line.

Each channel slot lasts 32 bit clocks. Only 16 of them carry sample bits, and the data line holds the last bit for the rest of the slot. A new pair is fetched from the FIFO at the start of every left slot. When no pair is waiting, the previous one is sent again.

The slot sequencer is a four-state machine:
- `ST_L_DATA` carries the left word.
- `ST_L_HOLD` holds its last bit.
- `ST_R_DATA` carries the right word.
- `ST_R_HOLD` holds its last bit.

The transitions, all taken on a bit-clock falling edge, are:
- L_DATA to L_HOLD after the sixteenth bit.
- L_HOLD to R_DATA at the end of the slot.
- R_DATA to R_HOLD after the sixteenth bit.
- R_HOLD to L_DATA at the end of the frame. This transition is where the FIFO fetch happens.

Top module: `i2s_stereo_tx`

## Requirements
- R1: `bclk_o` has a period of DIV reference clocks, with DIV = REF_HZ / (SAMPLE_HZ * 64) (default 8). It is high for DIV/2 cycles and low for DIV/2 cycles.
- R2: `ws_o` is 0 during the left slot and 1 during the right slot. It toggles every 32 bit-clock periods, and only at a bit-clock falling edge.
- R3: Counting bit-clock rising edges from 0 after a `ws_o` change, the sample word appears on `sdata_o` at rising edges 1 to 16, MSB first. Rising edge 0 still carries the last bit of the previous slot.
- R4: On rising edges 17 to 31 of a slot, `sdata_o` holds the word's LSB. `sdata_o` changes only at a bit-clock falling edge.
- R5: With SIGNED_INPUT=1, a CHANNEL_WIDTH-bit sample is left-justified into the 16-bit word and the low bits are filled with zeros. At width 16 the word equals the sample.
- R6: With SIGNED_INPUT=0, the word is a 0 bit, then the top min(CHANNEL_WIDTH,15) sample bits, then zeros. For width 12 the word is {0, s[11:0], 000}.
- R7: A pair is accepted on a `core_clk` edge where `samp_valid` is 1 and the FIFO (2^FIFO_AW entries, default 4) is not full. Accepted pairs are played in order, one per frame, fetched at the start of a left slot.
- R8: If the FIFO is empty at the start of a left slot, the previous pair is repeated. Before the first pair arrives, the output words are zero.
- R9: A pair offered while the FIFO is full is dropped and never appears on the output.
- R10: While `ref_rst_n` is low, `bclk_o`=0, `ws_o`=1 and `sdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core-domain clock |
| core_rst_n | input | 1 | Core-domain asynchronous reset, active low |
| samp_valid | input | 1 | Strobe: a stereo pair is present on the sample inputs |
| samp_left | input | CHANNEL_WIDTH | Left channel sample |
| samp_right | input | CHANNEL_WIDTH | Right channel sample |
| ref_clk | input | 1 | Audio reference clock |
| ref_rst_n | input | 1 | Audio-domain asynchronous reset, active low |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select: 0 left, 1 right |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
Two events can fall together in one cycle: a core-side write into the FIFO, and the audio-side fetch at a frame boundary. A further case is a write offered while the FIFO is already full.

The bench provokes both by waiting for the fall of word-select at a frame start, then issuing six back-to-back writes into the four-entry FIFO. The serial stream is decoded by a bench receiver model, and the frames played afterwards must be:
- the old pair,
- the four accepted pairs in order,
- then the fourth pair repeated.

The two dropped pairs must never appear.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int WORD_BITS  = 16;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * WORD_BITS;

    typedef enum logic [1:0] {
        ST_L_DATA,
        ST_L_HOLD,
        ST_R_DATA,
        ST_R_HOLD
    } slot_state_e;

    function automatic logic [FRAME_BITS/2:0] bin2gray3(input logic [FRAME_BITS/2:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
    parameter int DIV = 8
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    output logic bclk_o,
    output logic fall_tick
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // the edge on which the bit clock goes low
    assign fall_tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            cnt_q  <= '0;
            bclk_o <= 1'b0;
        end else begin
            if (fall_tick) begin
                cnt_q  <= '0;
                bclk_o <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(HALF - 1)) begin
                    bclk_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int W  = 32,
    parameter int AW = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin_q, wgray_q, rbin_q, rgray_q;
    logic [AW:0]  rg_w1_q, rg_w2_q, wg_r1_q, wg_r2_q;
    logic [AW:0]  wbin_n, rbin_n;

    assign wbin_n = wbin_q + 1'b1;
    assign rbin_n = rbin_q + 1'b1;

    // full: write gray equals read gray with the top two bits inverted
    assign full    = (wgray_q == {~rg_w2_q[AW:AW-1], rg_w2_q[AW-2:0]});
    assign empty   = (rgray_q == wg_r2_q);
    assign rd_data = mem[rbin_q[AW-1:0]];

    always_ff @(posedge wclk) begin
        if (wr_en && !full) begin
            mem[wbin_q[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            rg_w1_q <= '0;
            rg_w2_q <= '0;
        end else begin
            rg_w1_q <= rgray_q;
            rg_w2_q <= rg_w1_q;
            if (wr_en && !full) begin
                wbin_q  <= wbin_n;
                wgray_q <= wbin_n ^ (wbin_n >> 1);
            end
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            wg_r1_q <= '0;
            wg_r2_q <= '0;
        end else begin
            wg_r1_q <= wgray_q;
            wg_r2_q <= wg_r1_q;
            if (rd_en && !empty) begin
                rbin_q  <= rbin_n;
                rgray_q <= rbin_n ^ (rbin_n >> 1);
            end
        end
    end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
(
    input  logic                  ref_clk,
    input  logic                  ref_rst_n,
    input  logic                  fall_tick,
    input  logic                  fifo_empty,
    input  logic [FRAME_BITS-1:0] fifo_data,
    output logic                  fifo_pop,
    output logic                  ws_o,
    output logic                  sdata_o
);

    localparam int PW = $clog2(SLOT_BITS);
    localparam logic [PW-1:0] POS_LAST = PW'(SLOT_BITS - 1);
    localparam logic [PW-1:0] POS_DATA_END = PW'(WORD_BITS);

    slot_state_e           state_q, state_n;
    logic [PW-1:0]         pos_q, pos_n;
    logic [WORD_BITS-1:0]  sh_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic                  frame_start;

    assign pos_n       = pos_q + 1'b1;
    assign frame_start = fall_tick && (state_q == ST_R_HOLD) && (pos_q == POS_LAST);
    assign fifo_pop    = frame_start && !fifo_empty;

    // next-state selection
    always_comb begin
        state_n = state_q;
        if (fall_tick) begin
            unique case (state_q)
                ST_L_DATA: if (pos_q == POS_DATA_END) state_n = ST_L_HOLD;
                ST_L_HOLD: if (pos_q == POS_LAST)     state_n = ST_R_DATA;
                ST_R_DATA: if (pos_q == POS_DATA_END) state_n = ST_R_HOLD;
                ST_R_HOLD: if (pos_q == POS_LAST)     state_n = ST_L_DATA;
                default:                              state_n = ST_R_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            state_q <= ST_R_HOLD;
        end else begin
            state_q <= state_n;
        end
    end

    // outputs and datapath
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            pos_q   <= POS_LAST;
            ws_o    <= 1'b1;
            sdata_o <= 1'b0;
            sh_q    <= '0;
            frame_q <= '0;
        end else if (fall_tick) begin
            pos_q <= pos_n;
            if (pos_n == '0) begin
                ws_o <= ~ws_o;
                unique case (state_q)
                    ST_R_HOLD: begin
                        if (!fifo_empty) begin
                            frame_q <= fifo_data;
                            sh_q    <= fifo_data[FRAME_BITS-1:WORD_BITS];
                        end else begin
                            sh_q    <= frame_q[FRAME_BITS-1:WORD_BITS];
                        end
                    end
                    ST_L_HOLD: sh_q <= frame_q[WORD_BITS-1:0];
                    default:   sh_q <= sh_q;
                endcase
            end else if (pos_n <= POS_DATA_END) begin
                sdata_o <= sh_q[WORD_BITS-1];
                sh_q    <= {sh_q[WORD_BITS-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx
    import i2s_tx_pkg::*;
#(
    parameter int CHANNEL_WIDTH = 16,
    parameter bit SIGNED_INPUT  = 1'b1,
    parameter int REF_HZ        = 24_576_000,
    parameter int SAMPLE_HZ     = 48_000,
    parameter int FIFO_AW       = 2
) (
    input  logic                     core_clk,
    input  logic                     core_rst_n,
    input  logic                     samp_valid,
    input  logic [CHANNEL_WIDTH-1:0] samp_left,
    input  logic [CHANNEL_WIDTH-1:0] samp_right,
    input  logic                     ref_clk,
    input  logic                     ref_rst_n,
    output logic                     bclk_o,
    output logic                     ws_o,
    output logic                     sdata_o
);

    localparam int DIV      = REF_HZ / (SAMPLE_HZ * 2 * SLOT_BITS);
    localparam int HALF_DIV = DIV / 2;
    localparam int UW       = (CHANNEL_WIDTH > WORD_BITS - 1) ? WORD_BITS - 1 : CHANNEL_WIDTH;

    logic [WORD_BITS-1:0]  word_l, word_r;
    logic [FRAME_BITS-1:0] fifo_rd_data;
    logic                  fifo_full, fifo_empty, fifo_pop, fall_tick;

    generate
        if (SIGNED_INPUT) begin : g_signed
            assign word_l = WORD_BITS'(samp_left)  << (WORD_BITS - CHANNEL_WIDTH);
            assign word_r = WORD_BITS'(samp_right) << (WORD_BITS - CHANNEL_WIDTH);
        end else begin : g_unsigned
            logic [UW-1:0] top_l, top_r;
            assign top_l  = samp_left[CHANNEL_WIDTH-1 -: UW];
            assign top_r  = samp_right[CHANNEL_WIDTH-1 -: UW];
            assign word_l = WORD_BITS'(top_l) << (WORD_BITS - 1 - UW);
            assign word_r = WORD_BITS'(top_r) << (WORD_BITS - 1 - UW);
        end
    endgenerate

    i2s_tx_fifo #(.W(FRAME_BITS), .AW(FIFO_AW)) u_fifo (
        .wclk    (core_clk),
        .wrst_n  (core_rst_n),
        .wr_en   (samp_valid),
        .wr_data ({word_l, word_r}),
        .full    (fifo_full),
        .rclk    (ref_clk),
        .rrst_n  (ref_rst_n),
        .rd_en   (fifo_pop),
        .rd_data (fifo_rd_data),
        .empty   (fifo_empty)
    );

    i2s_tx_clkgen #(.DIV(DIV)) u_clkgen (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .bclk_o    (bclk_o),
        .fall_tick (fall_tick)
    );

    i2s_tx_serializer u_ser (
        .ref_clk    (ref_clk),
        .ref_rst_n  (ref_rst_n),
        .fall_tick  (fall_tick),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_rd_data),
        .fifo_pop   (fifo_pop),
        .ws_o       (ws_o),
        .sdata_o    (sdata_o)
    );

    logic unused_full;
    assign unused_full = fifo_full;

endmodule

// File: rtl/i2s_stereo_tx_chk.sv
module i2s_stereo_tx_chk #(
    parameter int DIV_HALF = 4
) (
    input logic ref_clk,
    input logic ref_rst_n,
    input logic bclk_o,
    input logic ws_o,
    input logic sdata_o
);

    localparam int CCW = $clog2(DIV_HALF + 2) + 1;

    logic           bclk_d, ws_d, sd_d, seen_q, fell;
    logic [CCW-1:0] cc_q;
    logic [4:0]     fc_q;

    assign fell = bclk_d && !bclk_o;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            bclk_d <= 1'b0;
            ws_d   <= 1'b1;
            sd_d   <= 1'b0;
            seen_q <= 1'b0;
            cc_q   <= '0;
            fc_q   <= '0;
        end else begin
            bclk_d <= bclk_o;
            ws_d   <= ws_o;
            sd_d   <= sdata_o;
            cc_q   <= (bclk_o != bclk_d) ? CCW'(1) : cc_q + 1'b1;
            if (fell) begin
                if (ws_o != ws_d) begin
                    fc_q   <= '0;
                    seen_q <= 1'b1;
                end else begin
                    fc_q <= fc_q + 1'b1;
                end
            end
        end
    end

    // R1: each bit-clock level lasts half the divide ratio
    a_r1_bclk_half: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (bclk_o != bclk_d) |-> (cc_q == CCW'(DIV_HALF)));

    // R2: word select moves only with a bit-clock fall
    a_r2_ws_on_fall: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (ws_o != ws_d) |-> fell);

    // R2: a slot is 32 bit clocks
    a_r2_slot_len: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (fell && (ws_o != ws_d) && seen_q) |-> (fc_q == 5'd31));

    // R4: data moves only with a bit-clock fall
    a_r4_data_on_fall: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (sdata_o != sd_d) |-> fell);

    // R4: data line frozen after the sixteenth bit of a slot
    a_r4_hold_tail: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (fell && seen_q && (fc_q >= 5'd16)) |-> (sdata_o == sd_d));

endmodule

bind i2s_stereo_tx i2s_stereo_tx_chk #(.DIV_HALF(HALF_DIV)) u_chk (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .bclk_o    (bclk_o),
    .ws_o      (ws_o),
    .sdata_o   (sdata_o)
);

// File: tb/test_i2s_stereo_tx.sv
`timescale 1ns/1ps

module i2s_rx_model (
    input  logic        bclk,
    input  logic        ws,
    input  logic        sdata,
    output logic [15:0] last_l,
    output logic [15:0] last_r,
    output int          frames,
    output int          err_hold,
    output int          err_slot,
    output int          err_lead
);
    logic [15:0] word;
    logic        ws_prev, prev_lsb, seen;
    int          idx;

    initial begin
        last_l = '0; last_r = '0; frames = 0;
        err_hold = 0; err_slot = 0; err_lead = 0;
        word = '0; ws_prev = 1'b1; prev_lsb = 1'b0; seen = 1'b0; idx = 0;
    end

    always @(posedge bclk) begin
        #1;
        if (ws != ws_prev) begin
            if (seen && idx != 31) err_slot++;
            seen = 1'b1;
            idx = 0;
        end else begin
            idx++;
        end
        ws_prev = ws;
        if (seen) begin
            if (idx == 0) begin
                if (sdata != prev_lsb) err_lead++;
            end else if (idx <= 16) begin
                word[16-idx] = sdata;
            end else if (sdata != word[0]) begin
                err_hold++;
            end
            if (idx == 31) begin
                prev_lsb = word[0];
                if (!ws) last_l = word;
                else begin
                    last_r = word;
                    frames++;
                end
            end
        end
    end
endmodule

module test_i2s_stereo_tx;

    logic        core_clk = 1'b0;
    logic        ref_clk  = 1'b0;
    logic        core_rst_n = 1'b0;
    logic        ref_rst_n  = 1'b0;
    logic        samp_valid = 1'b0;
    logic [15:0] samp_left  = '0;
    logic [15:0] samp_right = '0;
    logic        bclk_s, ws_s, sd_s, bclk_u, ws_u, sd_u;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [15:0] l_s, r_s, l_u, r_u;
    int fr_s, fr_u, eh_s, es_s, el_s, eh_u, es_u, el_u;

    always #2 core_clk = ~core_clk;
    always #5 ref_clk  = ~ref_clk;

    i2s_stereo_tx #(.CHANNEL_WIDTH(16), .SIGNED_INPUT(1'b1)) i_i2s_stereo_tx (
        .core_clk(core_clk), .core_rst_n(core_rst_n), .samp_valid(samp_valid),
        .samp_left(samp_left), .samp_right(samp_right),
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .bclk_o(bclk_s), .ws_o(ws_s), .sdata_o(sd_s));

    i2s_stereo_tx #(.CHANNEL_WIDTH(12), .SIGNED_INPUT(1'b0)) i_i2s_stereo_tx_u (
        .core_clk(core_clk), .core_rst_n(core_rst_n), .samp_valid(samp_valid),
        .samp_left(samp_left[11:0]), .samp_right(samp_right[11:0]),
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .bclk_o(bclk_u), .ws_o(ws_u), .sdata_o(sd_u));

    i2s_rx_model u_rx_s (.bclk(bclk_s), .ws(ws_s), .sdata(sd_s), .last_l(l_s), .last_r(r_s),
        .frames(fr_s), .err_hold(eh_s), .err_slot(es_s), .err_lead(el_s));
    i2s_rx_model u_rx_u (.bclk(bclk_u), .ws(ws_u), .sdata(sd_u), .last_l(l_u), .last_r(r_u),
        .frames(fr_u), .err_hold(eh_u), .err_slot(es_u), .err_lead(el_u));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] l, input logic [15:0] r);
        @(negedge core_clk);
        samp_left = l; samp_right = r; samp_valid = 1'b1;
        @(negedge core_clk);
        samp_valid = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int f0;
        f0 = fr_s;
        wait (fr_s >= f0 + n);
    endtask

    function automatic logic [15:0] uexp(input logic [15:0] s);
        return {1'b0, s[11:0], 3'b000};
    endfunction

    initial begin
        #2000;
        done = 1'b1;
        #1;
    end

    initial begin : main
        realtime t0, t1, t2;
        logic [15:0] pl, pr, old_l;
        logic [15:0] seq_l [6];
        #53;
        // R10: reset state
        check("R10 bclk", bclk_s, 0);
        check("R10 ws", ws_s, 1);
        check("R10 sdata", sd_s, 0);
        #50 core_rst_n = 1'b1; ref_rst_n = 1'b1;

        // R1: bit clock period and duty
        @(posedge bclk_s); t0 = $realtime;
        @(negedge bclk_s); t1 = $realtime;
        @(posedge bclk_s); t2 = $realtime;
        check("R1 high_ns", longint'(t1 - t0), 40);
        check("R1 period_ns", longint'(t2 - t0), 80);

        // R8: nothing written yet, zeros repeated
        wait_frames(2);
        check("R8 idle left", l_s, 0);
        check("R8 idle right", r_s, 0);

        // R5 R6 R7 R8: walking-one sweep
        for (int i = 0; i < 16; i++) begin
            pl = 16'h1 << i;
            pr = ~pl;
            push(pl, pr);
            wait_frames(3);
            check("R5 signed left", l_s, pl);
            check("R5 signed right", r_s, pr);
            check("R6 unsigned left", l_u, uexp(pl));
            check("R6 unsigned right", r_u, uexp(pr));
            wait_frames(1);
            check("R8 repeat left", l_s, pl);
            check("R8 repeat right", r_s, pr);
        end

        // R7 R9: burst of six into a four-entry FIFO right after a frame fetch
        old_l = l_s;
        @(negedge ws_s);
        for (int k = 0; k < 6; k++) begin
            @(negedge core_clk);
            samp_left = 16'hA000 + 16'(k); samp_right = 16'h5000 + 16'(k); samp_valid = 1'b1;
        end
        @(negedge core_clk);
        samp_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            wait_frames(1);
            seq_l[k] = l_s;
        end
        check("R7 frame0 old", seq_l[0], old_l);
        for (int k = 0; k < 4; k++) begin
            check("R7 order", seq_l[k+1], 16'hA000 + 16'(k));
        end
        check("R9 dropped not played", seq_l[5], 16'hA003);
        check("R7 right last", r_s, 16'h5003);

        // R2 R3 R4: stream structure seen by the receiver models
        check("R2 slot length signed", es_s, 0);
        check("R2 slot length unsigned", es_u, 0);
        check("R3 lead bit signed", el_s, 0);
        check("R3 lead bit unsigned", el_u, 0);
        check("R4 hold signed", eh_s, 0);
        check("R4 hold unsigned", eh_u, 0);
        check("R2 ws equal", ws_s, ws_u);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (170000) @(posedge core_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule